// File: doc/BRIEF.md
# Four-Activate Window Limiter

This block watches row activates on a memory channel and keeps each rank within a sliding-window budget. At most `ACT_LIMIT` activates, four by default, may fall in any span of `WINDOW` consecutive memory-bus cycles. Two command sources feed it. The request path reports ordinary row opens, and the refresh path reports refresh commands. Both sources count against the same per-rank budget.

The scheduler looks at the one-bit permission for a rank before it issues an activate there. Each rank keeps a short history register. A new activate enters this register at the far end and moves one place per cycle toward the exit. A counter keeps the number of set bits, so the permission depends only on a small comparison. The comparison does not grow with the window length.

When `WINDOW` is zero, the block records nothing, and every rank is always allowed.

Top module: `fawl_limiter`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, `act_allow` is all ones.
- R2: Suppose four activates to one rank are sampled on consecutive clock edges. In the cycle after the fourth edge, that rank's `act_allow` bit is 0.
- R3: Suppose an activate is sampled on edge k and three more follow on edges k+1 to k+3. The rank stays blocked through the cycle after edge k+WINDOW-2. It is allowed again in the cycle after edge k+WINDOW-1, so a fifth activate can be taken on edge k+WINDOW.
- R4: An activate to one rank never changes the `act_allow` bit of any other rank. The rank is selected by the binary index on `req_act_rank` or `ref_act_rank`.
- R5: A refresh activate (`ref_act_valid` high with `ref_act_rank`) uses the window budget in exactly the same way as a request activate.
- R6: A request activate and a refresh activate to the same rank on the same edge are recorded as one activate.
- R7: Suppose an old activate leaves the window on the same edge that a new activate to that rank is recorded. The rank's count is unchanged. As a result, blocking and release follow the new activate exactly W cycles later.
- R8: An activate presented to a blocked rank is still recorded. It lengthens the blocked period.
- R9: A source that issues only while its rank is allowed produces activates where the fifth lands at least WINDOW edges after the first.
- R10: With `WINDOW` = 0, `act_allow` is all ones in every cycle, whatever activates are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_act_valid | input | 1 | A request activate is issued this cycle |
| req_act_rank | input | RANK_W | Rank index of the request activate |
| ref_act_valid | input | 1 | A refresh activate is issued this cycle |
| ref_act_rank | input | RANK_W | Rank index of the refresh activate |
| act_allow | output | NUM_RANKS | Per-rank permission to issue a new activate |

## Verification
Two things can land on the same edge for one rank: the oldest recorded activate leaves the window, and a new activate enters it. The bench causes this by filling a rank with four activates, waiting until it is allowed again, and then issuing four more activates on exactly the edges where the earlier four expire. The count is judged correct when the rank is blocked right after the second group, is still blocked WINDOW-2 edges later, and is released on the next edge. A lost increment would release the rank early, and a lost decrement would hold it blocked too long.

// File: rtl/fawl_pkg.sv
package fawl_pkg;

   // Widest history register the block supports.
   localparam int WINDOW_MAX = 62;

   // Bits needed for a rank index.
   function automatic int rank_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Bits needed to hold a count of 0..w.
   function automatic int count_bits(input int w);
      return (w > 0) ? $clog2(w + 1) : 1;
   endfunction

endpackage

// File: rtl/fawl_rank_decode.sv
module fawl_rank_decode #(
   parameter int NUM_RANKS = 4,
   parameter int RANK_W    = 2
) (
   input  logic                 valid,
   input  logic [RANK_W-1:0]    rank,
   output logic [NUM_RANKS-1:0] hit
);

   always_comb begin
      hit = '0;
      for (int r = 0; r < NUM_RANKS; r++) begin
         if (valid && (rank == RANK_W'(r))) hit[r] = 1'b1;
      end
   end

endmodule

// File: rtl/fawl_rank_window.sv
module fawl_rank_window #(
   parameter int WINDOW    = 16,
   parameter int ACT_LIMIT = 4,
   parameter int CNT_W     = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mark,
   output logic allow
);

   logic [WINDOW-1:0] hist_q, hist_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_live;

   // cnt_live is the count after this cycle's expiry, so the oldest
   // entry no longer blocks in the cycle it leaves.
   always_comb begin
      cnt_live = cnt_q - CNT_W'(hist_q[0]);
      hist_d   = hist_q >> 1;
      hist_d[WINDOW-1] = hist_d[WINDOW-1] | mark;
      cnt_d    = cnt_live + CNT_W'(mark);
   end

   assign allow = (cnt_live < CNT_W'(ACT_LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
         cnt_q  <= '0;
      end else begin
         hist_q <= hist_d;
         cnt_q  <= cnt_d;
      end
   end

endmodule

// File: rtl/fawl_limiter.sv
module fawl_limiter
   import fawl_pkg::*;
#(
   parameter int NUM_RANKS = 4,
   parameter int WINDOW    = 16,
   parameter int ACT_LIMIT = 4,
   localparam int RANK_W   = rank_bits(NUM_RANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_act_valid,
   input  logic [RANK_W-1:0]    req_act_rank,
   input  logic                 ref_act_valid,
   input  logic [RANK_W-1:0]    ref_act_rank,
   output logic [NUM_RANKS-1:0] act_allow
);

   localparam int CNT_W = count_bits(WINDOW);

   // Parameter checks at elaboration.
   if (NUM_RANKS < 1) begin : g_bad_ranks
      $error("fawl_limiter: NUM_RANKS must be at least 1");
   end
   if ((WINDOW < 0) || (WINDOW > WINDOW_MAX)) begin : g_bad_window
      $error("fawl_limiter: WINDOW out of range 0..%0d", WINDOW_MAX);
   end
   if ((WINDOW > 0) && ((ACT_LIMIT < 1) || (ACT_LIMIT > WINDOW))) begin : g_bad_limit
      $error("fawl_limiter: ACT_LIMIT must lie in 1..WINDOW");
   end

   logic [NUM_RANKS-1:0] req_hit, ref_hit, mark;

   fawl_rank_decode #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_req_dec (
      .valid (req_act_valid),
      .rank  (req_act_rank),
      .hit   (req_hit)
   );

   fawl_rank_decode #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_ref_dec (
      .valid (ref_act_valid),
      .rank  (ref_act_rank),
      .hit   (ref_hit)
   );

   // Both sources share one slot per rank per cycle.
   assign mark = req_hit | ref_hit;

   if (WINDOW == 0) begin : g_off
      assign act_allow = '1;
   end else begin : g_on
      for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
         fawl_rank_window #(
            .WINDOW    (WINDOW),
            .ACT_LIMIT (ACT_LIMIT),
            .CNT_W     (CNT_W)
         ) u_win (
            .clk   (clk),
            .rst_n (rst_n),
            .mark  (mark[r]),
            .allow (act_allow[r])
         );
      end
   end

endmodule

// File: rtl/fawl_limiter_chk.sv
module fawl_limiter_chk #(
   parameter int NUM_RANKS = 4,
   parameter int WINDOW    = 16,
   parameter int RANK_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_act_valid,
   input logic [RANK_W-1:0]    req_act_rank,
   input logic                 ref_act_valid,
   input logic [RANK_W-1:0]    ref_act_rank,
   input logic [NUM_RANKS-1:0] act_allow
);

   logic [NUM_RANKS-1:0] seen;

   always_comb begin
      for (int r = 0; r < NUM_RANKS; r++) begin
         seen[r] = (req_act_valid && (req_act_rank == RANK_W'(r))) ||
                   (ref_act_valid && (ref_act_rank == RANK_W'(r)));
      end
   end

   // R1
   reset_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (act_allow == '1));

   if (WINDOW == 0) begin : g_off_chk
      // R10
      disabled_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
         act_allow == '1);
   end else begin : g_on_chk
      for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
         // R4
         idle_keeps_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_allow[r] && !seen[r]) |=> act_allow[r]);
         // R8
         busy_act_keeps_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!act_allow[r] && seen[r]) |=> !act_allow[r]);
         // R2
         shut_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(act_allow[r]) |-> $past(seen[r]));
      end
   end

endmodule

bind fawl_limiter fawl_limiter_chk #(
   .NUM_RANKS (NUM_RANKS),
   .WINDOW    (WINDOW),
   .RANK_W    (RANK_W)
) u_fawl_chk (.*);

// File: tb/test_fawl_limiter.sv
`timescale 1ns/1ps
module test_fawl_limiter;

   localparam int NR = 4;
   localparam int W  = 16;
   localparam int RW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_v = 1'b0;
   logic [RW-1:0] req_r = '0;
   logic          ref_v = 1'b0;
   logic [RW-1:0] ref_r = '0;
   logic [NR-1:0] allow, allow_off;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   fawl_limiter #(.NUM_RANKS(NR), .WINDOW(W), .ACT_LIMIT(4)) i_fawl_limiter (
      .clk (clk), .rst_n (rst_n),
      .req_act_valid (req_v), .req_act_rank (req_r),
      .ref_act_valid (ref_v), .ref_act_rank (ref_r),
      .act_allow (allow)
   );

   fawl_limiter #(.NUM_RANKS(NR), .WINDOW(0), .ACT_LIMIT(4)) i_fawl_limiter_off (
      .clk (clk), .rst_n (rst_n),
      .req_act_valid (req_v), .req_act_rank (req_r),
      .ref_act_valid (ref_v), .ref_act_rank (ref_r),
      .act_allow (allow_off)
   );

   task automatic check_val(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Drive one cycle of stimulus, return at the next falling edge.
   task automatic step(input logic rv, input logic [RW-1:0] rr,
                       input logic fv, input logic [RW-1:0] fr);
      req_v = rv; req_r = rr; ref_v = fv; ref_r = fr;
      @(negedge clk);
      req_v = 1'b0; ref_v = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0);
   endtask

   task automatic act(input int rank, input int n);
      for (int i = 0; i < n; i++) step(1'b1, RW'(rank), 1'b0, '0);
   endtask

   task automatic t_reset;
      check_val("R1 allow in reset", int'(allow), 15);
      rst_n = 1'b1;
      @(negedge clk);
      check_val("R1 allow after reset", int'(allow), 15);
      check_val("R10 disabled after reset", int'(allow_off), 15);
   endtask

   task automatic t_block_expire;
      act(1, 3);
      check_val("R2 three acts still allowed", int'(allow[1]), 1);
      act(1, 1);
      check_val("R2 blocked after fourth", int'(allow[1]), 0);
      check_val("R4 other ranks open", int'(allow & 4'b1101), 13);
      check_val("R10 disabled ignores acts", int'(allow_off), 15);
      idle(W - 5);
      check_val("R3 blocked at edge k+W-2", int'(allow[1]), 0);
      idle(1);
      check_val("R3 released at edge k+W-1", int'(allow[1]), 1);
      idle(W + 2);
   endtask

   task automatic t_refresh;
      for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, RW'(2));
      check_val("R5 three refreshes allowed", int'(allow[2]), 1);
      act(2, 1);
      check_val("R5 refresh counted", int'(allow[2]), 0);
      check_val("R10 disabled ignores refresh", int'(allow_off), 15);
      idle(W + 2);
   endtask

   task automatic t_dual;
      act(3, 2);
      step(1'b1, RW'(3), 1'b1, RW'(3));
      check_val("R6 dual mark counted once", int'(allow[3]), 1);
      act(3, 1);
      check_val("R6 fourth act blocks", int'(allow[3]), 0);
      idle(W + 2);
   endtask

   task automatic t_collide;
      act(0, 4);
      idle(W - 4);
      check_val("R7 released before second group", int'(allow[0]), 1);
      act(0, 4);   // each lands on an expiry edge
      check_val("R7 blocked after colliding group", int'(allow[0]), 0);
      idle(W - 5);
      check_val("R7 still blocked", int'(allow[0]), 0);
      idle(1);
      check_val("R7 released on time", int'(allow[0]), 1);
      idle(W + 2);
   endtask

   task automatic t_blocked_act;
      act(1, 5);
      check_val("R8 blocked after extra act", int'(allow[1]), 0);
      idle(W - 5);
      check_val("R8 extra act extends block", int'(allow[1]), 0);
      idle(1);
      check_val("R8 released one later", int'(allow[1]), 1);
      idle(W + 2);
   endtask

   task automatic t_greedy;
      int n = 0, first = -1, last = -1, cyc = 0;
      while ((n < 5) && (cyc < 200)) begin
         if (allow[2]) begin
            if (first < 0) first = cyc;
            last = cyc;
            n++;
            act(2, 1);
         end else begin
            idle(1);
         end
         cyc++;
      end
      check_val("R9 five acts issued", n, 5);
      check_val("R9 span at least window", int'(last - first >= W), 1);
      check_val("R3 greedy span equals window", last - first, W);
      idle(W + 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_block_expire();
      t_refresh();
      t_dual();
      t_collide();
      t_blocked_act();
      t_greedy();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all): actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule